// File: doc/BRIEF.md
# Legacy Memory Attribute Router

This block steers host memory accesses that land in the legacy window from 0C0000h to 0FFFFFh. Each access goes either to main memory (DRAM) or to the expansion bus. Seven byte-wide attribute registers sit in configuration space at offsets 90h to 96h. Together they split the window into thirteen segments. There are twelve 16 KB segments from 0C0000h to 0EFFFFh and one 64 KB segment from 0F0000h to 0FFFFFh. Each segment has its own read-enable bit and its own write-enable bit.

Reads and writes are steered independently. Firmware can therefore shadow a ROM image with write-only mode. In that mode a read of an address fetches from the expansion bus, and a write of the same address stores into DRAM. Afterwards the segment can be switched to read-only mode, so reads are served from DRAM and writes go to the bus. Addresses outside the legacy window always go to DRAM.

The route outputs are combinational from the host address and the registered attribute bits. A configuration write therefore steers the host access made in the following clock cycle.

Top module: `legacy_attr_router`

## Requirements
- R1: A config write with `cfg_off` in 90h..96h stores the byte, and a config read of that offset returns the stored bits in the same cycle. Any other offset reads 00h and stores nothing.
- R2: Reserved bits are dropped on write and read back as 0. Offset 90h keeps only bits 5:4 (mask 30h). Offsets 91h..96h keep bits 5:4 and 1:0 (mask 33h).
- R3: After reset every attribute bit is 0. Every offset reads 00h, and every access in the legacy window routes to the expansion bus.
- R4: The segment map is as follows. Offset 90h bits 5:4 cover 0F0000h..0FFFFFh. For k = 0..5, offset 91h+k covers two segments. Its bits 1:0 cover 0C0000h + k*8000h through the next 16 KB. Its bits 5:4 cover the 16 KB segment that follows.
- R5: A host read to a segment whose read enable is 1 routes to DRAM. The read enable is bit 0 for a low field and bit 4 for a high field. When the read enable is 0, the read routes to the bus.
- R6: A host write to a segment whose write enable is 1 routes to DRAM. The write enable is bit 1 for a low field and bit 5 for a high field. When the write enable is 0, the write routes to the bus.
- R7: In write-only mode (read enable 0, write enable 1), a read and a write of the same address route to the bus and to DRAM respectively.
- R8: In read-only mode (read enable 1, write enable 0), reads route to DRAM and writes route to the bus.
- R9: A host access below 0C0000h or above 0FFFFFh routes to DRAM whatever the attribute bits hold.
- R10: While `host_valid` is 1, exactly one of `route_dram` and `route_bus` is 1. While `host_valid` is 0, both are 0.
- R11: The route is combinational from the current address and register values. A config write at a clock edge changes the route of the access presented after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_off | input | 8 | Config byte offset for reads and writes |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data for `cfg_off` |
| host_valid | input | 1 | Host access present |
| host_write | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | ADDR_W (32) | Host byte address |
| route_dram | output | 1 | Access goes to main memory |
| route_bus | output | 1 | Access goes to the expansion bus |

## Verification
The main test is a sweep that enables one segment's read bit at a time and probes the first and last byte of all thirteen segments. This separates a correct address slicing from an off-by-one field or register choice. Pairs of a read and a write to the same address, in write-only and read-only modes, check that read and write enables are kept apart. Addresses outside the window and a long random mix of config writes, reserved-bit patterns and host accesses are compared every cycle with a behavioural model. A config write issued while a host access is held shows the one-edge latency of a change in steering.

// File: rtl/legacy_attr_pkg.sv
package legacy_attr_pkg;
    localparam int ATTR_REGS = 7;
    localparam int IDX_W     = $clog2(ATTR_REGS);
    localparam int BYTE_W    = 8;

    typedef logic [BYTE_W-1:0]      attr_byte_t;
    typedef attr_byte_t [ATTR_REGS-1:0] attr_bank_t;

    // register 0 holds only the 64 KB top segment in its upper field
    localparam attr_byte_t TOP_MASK  = 8'h30;
    localparam attr_byte_t PAIR_MASK = 8'h33;

    // bit positions inside one field pair
    localparam int RD_BIT   = 0;
    localparam int WR_BIT   = 1;
    localparam int HI_SHIFT = 4;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] reg_idx;
        logic             hi_field;
    } seg_sel_t;

    typedef struct packed {
        attr_bank_t bank;
    } regfile_state_t;
endpackage

// File: rtl/attr_regfile.sv
module attr_regfile
    import legacy_attr_pkg::*;
#(
    parameter int OFF_W    = 8,
    parameter int BASE_OFF = 'h90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [OFF_W-1:0] cfg_off,
    input  attr_byte_t       cfg_wdata,
    output attr_byte_t       cfg_rdata,
    output attr_bank_t       bank_o
);
    localparam logic [OFF_W-1:0] BASE_L  = OFF_W'(BASE_OFF);
    localparam logic [OFF_W-1:0] COUNT_L = OFF_W'(ATTR_REGS);

    regfile_state_t   st_d, st_q;
    attr_bank_t       keep_mask;
    logic [OFF_W-1:0] off_rel;
    logic             off_hit;
    logic [IDX_W-1:0] off_idx;

    for (genvar g = 0; g < ATTR_REGS; g++) begin : g_mask
        if (g == 0) begin : g_top
            assign keep_mask[g] = TOP_MASK;
        end else begin : g_pair
            assign keep_mask[g] = PAIR_MASK;
        end
    end

    assign off_rel = cfg_off - BASE_L;
    assign off_hit = (cfg_off >= BASE_L) && (off_rel < COUNT_L);
    assign off_idx = off_rel[IDX_W-1:0];

    always_comb begin
        st_d = st_q;
        if (cfg_we && off_hit) begin
            st_d.bank[off_idx] = cfg_wdata & keep_mask[off_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (off_hit) begin
            cfg_rdata = st_q.bank[off_idx];
        end
    end

    assign bank_o = st_q.bank;
endmodule

// File: rtl/seg_decode.sv
module seg_decode
    import legacy_attr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output seg_sel_t          sel
);
    // window 0C0000h..0FFFFFh: zero above bit 19, bits 19:18 both set
    localparam int WIN_HI  = 20;
    localparam int QUAD_LO = 16;
    localparam int SEG_LO  = 14;

    logic              upper_zero;
    logic              in_win;
    logic              top_seg;
    logic [IDX_W-1:0]  pair_idx;

    assign upper_zero = (addr[ADDR_W-1:WIN_HI] == '0);
    assign in_win     = upper_zero && (addr[WIN_HI-1:WIN_HI-2] == 2'b11);
    assign top_seg    = (addr[WIN_HI-3:QUAD_LO] == 2'b11);
    assign pair_idx   = IDX_W'(addr[WIN_HI-3:SEG_LO+1]) + IDX_W'(1);

    always_comb begin
        sel.hit      = in_win;
        sel.reg_idx  = top_seg ? '0 : pair_idx;
        sel.hi_field = top_seg ? 1'b1 : addr[SEG_LO];
    end
endmodule

// File: rtl/route_select.sv
module route_select
    import legacy_attr_pkg::*;
(
    input  seg_sel_t   sel,
    input  attr_bank_t bank,
    input  logic       host_valid,
    input  logic       host_write,
    output logic       route_dram,
    output logic       route_bus
);
    attr_byte_t entry;
    logic [3:0] field;
    logic       enable;

    always_comb begin
        entry  = bank[sel.reg_idx];
        field  = sel.hi_field ? entry[HI_SHIFT +: 4] : entry[3:0];
        enable = host_write ? field[WR_BIT] : field[RD_BIT];
        route_dram = host_valid && (!sel.hit || enable);
        route_bus  = host_valid && sel.hit && !enable;
    end
endmodule

// File: rtl/legacy_attr_router.sv
module legacy_attr_router
    import legacy_attr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BASE_OFF = 'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_off,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              route_dram,
    output logic              route_bus
);
    attr_bank_t bank;
    seg_sel_t   sel;

    attr_regfile #(
        .OFF_W    (8),
        .BASE_OFF (BASE_OFF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_off   (cfg_off),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bank_o    (bank)
    );

    seg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (host_addr),
        .sel  (sel)
    );

    route_select u_route (
        .sel        (sel),
        .bank       (bank),
        .host_valid (host_valid),
        .host_write (host_write),
        .route_dram (route_dram),
        .route_bus  (route_bus)
    );
endmodule

// File: rtl/legacy_attr_router_chk.sv
module legacy_attr_router_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_off,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic              host_valid,
    input logic              host_write,
    input logic [ADDR_W-1:0] host_addr,
    input logic              route_dram,
    input logic              route_bus
);
    logic       off_ok;
    logic [7:0] ok_bits;
    logic       outside;

    assign off_ok  = (cfg_off >= 8'h90) && (cfg_off <= 8'h96);
    assign ok_bits = (cfg_off == 8'h90) ? 8'h30 : 8'h33;
    assign outside = (host_addr < ADDR_W'(32'h000C_0000)) ||
                     (host_addr > ADDR_W'(32'h000F_FFFF));

    // R10: one target per access
    assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |-> ($countones({route_dram, route_bus}) == 1));

    // R10: idle host drives no route
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |-> (!route_dram && !route_bus));

    // R9: outside the window always main memory
    assert_outside_dram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && outside) |-> route_dram);

    // R2: reserved positions read as zero
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        off_ok |-> ((cfg_rdata & ~ok_bits) == 8'h00));

    // R1: unmapped offsets read zero
    assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !off_ok |-> (cfg_rdata == 8'h00));

    // R1: written value visible on the next cycle at the same offset
    assert_write_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && off_ok) |=>
            ((cfg_off != $past(cfg_off)) || (cfg_rdata == ($past(cfg_wdata) & $past(ok_bits)))));
endmodule

bind legacy_attr_router legacy_attr_router_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_off    (cfg_off),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .host_valid (host_valid),
    .host_write (host_write),
    .host_addr  (host_addr),
    .route_dram (route_dram),
    .route_bus  (route_bus)
);

// File: tb/sim_legacy_attr_router.sv
`timescale 1ns/1ps
module sim_legacy_attr_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_off = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [31:0] host_addr = 32'h0;
    logic        route_dram, route_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] ref_regs [7];

    always #4 clk = ~clk;

    legacy_attr_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_valid(host_valid),
        .host_write(host_write), .host_addr(host_addr),
        .route_dram(route_dram), .route_bus(route_bus)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference of the register contents
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) ref_regs[i] <= 8'h00;
        end else if (cfg_we && cfg_off >= 8'h90 && cfg_off <= 8'h96) begin
            ref_regs[cfg_off - 8'h90] <= cfg_wdata & ((cfg_off == 8'h90) ? 8'h30 : 8'h33);
        end
    end

    function automatic logic exp_dram(input logic [31:0] a, input logic w);
        int idx, r, sh;
        if (a < 32'h000C_0000 || a > 32'h000F_FFFF) return 1'b1;
        if (a >= 32'h000F_0000) begin
            r = 0; sh = 4;
        end else begin
            idx = int'((a - 32'h000C_0000) >> 14);
            r = 1 + idx / 2;
            sh = (idx % 2 == 1) ? 4 : 0;
        end
        return ref_regs[r][sh + (w ? 1 : 0)];
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic ed;
            string t;
            ed = exp_dram(host_addr, host_write);
            if (!host_valid) t = "R10";
            else if (host_addr < 32'h000C_0000 || host_addr > 32'h000F_FFFF) t = "R9";
            else if (host_write) t = "R6";
            else t = "R5";
            chk(t, {31'd0, route_dram}, {31'd0, host_valid && ed});
            chk(t, {31'd0, route_bus},  {31'd0, host_valid && !ed});
            chk("R1", {24'd0, cfg_rdata},
                (cfg_off >= 8'h90 && cfg_off <= 8'h96) ? {24'd0, ref_regs[cfg_off - 8'h90]} : 32'd0);
        end
    end

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] data);
        cfg_we = 1'b1; cfg_off = off; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input string tag, input logic [7:0] off, input logic [7:0] exp);
        cfg_off = off;
        @(negedge clk);
        chk(tag, {24'd0, cfg_rdata}, {24'd0, exp});
        @(posedge clk); #1;
    endtask

    // exp_d: 1 means DRAM expected, 0 means expansion bus
    task automatic probe(input string tag, input logic [31:0] a, input logic w, input logic exp_d);
        host_valid = 1'b1; host_write = w; host_addr = a;
        @(negedge clk);
        chk(tag, {30'd0, route_dram, route_bus}, {30'd0, exp_d, !exp_d});
        @(posedge clk); #1;
        host_valid = 1'b0;
    endtask

    function automatic logic [31:0] seg_base(input int p);
        return (p < 12) ? 32'h000C_0000 + 32'(p) * 32'h4000 : 32'h000F_0000;
    endfunction

    function automatic logic [31:0] seg_last(input int p);
        return (p < 12) ? seg_base(p) + 32'h3FFF : 32'h000F_FFFF;
    endfunction

    task automatic clear_all();
        for (int i = 0; i < 7; i++) cfg_write(8'h90 + 8'(i), 8'h00);
    endtask

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R3: reset state
        for (int i = 0; i < 7; i++) cfg_read("R3", 8'h90 + 8'(i), 8'h00);
        probe("R3", 32'h000C_0000, 1'b0, 1'b0);
        probe("R3", 32'h000F_8000, 1'b1, 1'b0);

        // R2: reserved bits dropped
        cfg_write(8'h90, 8'hFF);
        cfg_read("R2", 8'h90, 8'h30);
        cfg_write(8'h91, 8'hFF);
        cfg_read("R2", 8'h91, 8'h33);
        cfg_write(8'h96, 8'hCC);
        cfg_read("R2", 8'h96, 8'h00);

        // R1: unmapped offsets
        cfg_write(8'h97, 8'hFF);
        cfg_read("R1", 8'h97, 8'h00);
        cfg_read("R1", 8'h8F, 8'h00);
        cfg_write(8'h95, 8'h21);
        cfg_read("R1", 8'h95, 8'h21);

        // R4: one segment read-enabled at a time, probe every segment's ends
        for (int s = 0; s < 13; s++) begin
            clear_all();
            if (s == 12) cfg_write(8'h90, 8'h10);
            else cfg_write(8'h91 + 8'(s / 2), (s % 2 == 1) ? 8'h10 : 8'h01);
            for (int p = 0; p < 13; p++) begin
                probe("R4", seg_base(p), 1'b0, p == s);
                probe("R4", seg_last(p), 1'b0, p == s);
            end
        end

        // R6: write enable in low and high fields
        clear_all();
        cfg_write(8'h92, 8'h20);
        probe("R6", 32'h000C_C000, 1'b1, 1'b1);
        probe("R6", 32'h000C_8000, 1'b1, 1'b0);
        probe("R5", 32'h000C_C000, 1'b0, 1'b0);

        // R7: write-only shadow mode
        cfg_write(8'h95, 8'h02);
        probe("R7", 32'h000E_1234, 1'b0, 1'b0);
        probe("R7", 32'h000E_1234, 1'b1, 1'b1);

        // R8: read-only mode
        cfg_write(8'h95, 8'h01);
        probe("R8", 32'h000E_1234, 1'b0, 1'b1);
        probe("R8", 32'h000E_1234, 1'b1, 1'b0);

        // R9: outside the window
        probe("R9", 32'h000B_FFFF, 1'b0, 1'b1);
        probe("R9", 32'h0010_0000, 1'b1, 1'b1);
        probe("R9", 32'hFFFF_FFFF, 1'b0, 1'b1);

        // R10: idle host
        host_valid = 1'b0;
        @(negedge clk);
        chk("R10", {30'd0, route_dram, route_bus}, 32'd0);
        @(posedge clk); #1;

        // R11: steering changes only after the config edge
        host_valid = 1'b1; host_write = 1'b0; host_addr = 32'h000D_0000;
        cfg_we = 1'b1; cfg_off = 8'h93; cfg_wdata = 8'h01;
        @(negedge clk);
        chk("R11", {31'd0, route_bus}, 32'd1);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        @(negedge clk);
        chk("R11", {31'd0, route_dram}, 32'd1);
        @(posedge clk); #1;
        host_valid = 1'b0;

        // random mix compared every cycle by the model
        for (int c = 0; c < 3000; c++) begin
            cfg_we = ($urandom % 8) == 0;
            cfg_off = 8'h8E + 8'($urandom % 11);
            cfg_wdata = 8'($urandom);
            host_valid = ($urandom % 4) != 0;
            host_write = $urandom % 2;
            if (($urandom % 4) == 0) host_addr = $urandom;
            else host_addr = 32'h000C_0000 + ($urandom % 32'h40000);
            @(posedge clk); #1;
        end
        cfg_we = 1'b0;
        host_valid = 1'b0;
        @(negedge clk);
        summary();
    end
endmodule